// File: doc/BRIEF.md
# Gigabit PCS Transmit Code-Group Sequencer

This block sits between a byte-wide GMII transmit interface and an 8b10b encoder in a gigabit Ethernet physical coding sublayer. It takes one data byte and an enable strobe per 125 MHz cycle. Each cycle it emits one 8-bit code group and a flag that marks special (K) characters. The downstream encoder turns that pair into a 10-bit symbol.

Between frames the block sends a steady stream of two-code-group idle sets, each starting on an even position. When a frame arrives, its first byte is replaced by a start delimiter. The remaining bytes pass through unchanged. An end delimiter, a carrier-extend character and, if needed, one padding character then close the frame so that idle resumes on an even position. A frame whose enable rises in the middle of an idle set waits for that set to finish. Its bytes are then shifted one cycle later, and its length does not change.

Top module: `pcs_tx_coder`

## Requirements
- R1: While no frame is in progress, the output alternates K28.5 (0xBC, flag 1) on even positions and D16.2 (0x50, flag 0) on odd positions.
- R2: Reset is synchronous and active high. While it is held, the output is 0xBC with flag 1. The first code group after release is 0x50 with flag 0, in the odd position.
- R3: A frame whose enable is first sampled in a cycle whose next output position is even emits K27.7 (0xFB, flag 1) in place of its first byte, one cycle after that sample.
- R4: Frame bytes after the first appear on the output unchanged and in order, with flag 0, one per cycle.
- R5: The cycle after the last frame byte carries K29.7 (0xFD, flag 1), and the cycle after that carries K23.7 (0xF7, flag 1).
- R6: If the position after that end pair is odd, one more 0xF7 with flag 1 is sent. The idle pattern then resumes with 0xBC on an even position.
- R7: If the enable is first sampled when the next output position is odd, 0x50 is sent first and 0xFB follows on the next cycle. Every later code group of the frame is one cycle later than in R3, and the frame still occupies as many code groups as it had GMII bytes.
- R8: A one-byte frame produces 0xFB followed directly by the end pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz code-group clock |
| rst | input | 1 | Synchronous active-high reset |
| gmii_en | input | 1 | GMII transmit enable |
| gmii_d | input | 8 | GMII transmit byte |
| cg_data | output | 8 | Code group to the 8b10b encoder |
| cg_is_k | output | 1 | High when cg_data is a special character |

## Verification
Two events can fall in the same cycle. A frame can start while the second half of an idle set is due, and a frame can end on a position that forces the alignment pad. The bench sends frames of every length from 1 to 24 bytes, each starting on both output parities. This provokes the delayed start and the padded and unpadded endings in every combination. Every output cycle is compared against a position-indexed expectation computed from the frame's start cycle and length.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
   localparam int unsigned CG_W = 8;

   localparam logic [CG_W-1:0] CG_COMMA   = 8'hBC; // K28.5
   localparam logic [CG_W-1:0] CG_IDLE_D  = 8'h50; // D16.2
   localparam logic [CG_W-1:0] CG_SOP     = 8'hFB; // K27.7
   localparam logic [CG_W-1:0] CG_EOP     = 8'hFD; // K29.7
   localparam logic [CG_W-1:0] CG_CARRIER = 8'hF7; // K23.7

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FRAME,
      ST_TERM,
      ST_PAD
   } tx_state_e;
endpackage

// File: rtl/tx_parity_toggle.sv
module tx_parity_toggle (
   input  logic clk,
   input  logic rst,
   output logic next_odd
);
   // Parity of the code group the next clock edge will produce.
   // Reset loads the even idle comma, so the first free edge is odd.
   always_ff @(posedge clk) begin
      if (rst) next_odd <= 1'b1;
      else     next_odd <= ~next_odd;
   end
endmodule

// File: rtl/tx_byte_pipe.sv
module tx_byte_pipe #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_en,
   input  logic [W-1:0]              in_d,
   output logic [DEPTH-1:0]          tap_en,
   output logic [DEPTH-1:0][W-1:0]   tap_d
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("tx_byte_pipe needs at least two stages");
   end

   always_ff @(posedge clk) begin
      if (rst) tap_en <= '0;
      else     tap_en <= {tap_en[DEPTH-2:0], in_en};
      tap_d <= {tap_d[DEPTH-2:0], in_d};
   end
endmodule

// File: rtl/tx_cg_fsm.sv
module tx_cg_fsm
   import pcs_tx_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         next_odd,
   input  logic         en_a,
   input  logic [W-1:0] d_a,
   input  logic         en_b,
   input  logic [W-1:0] d_b,
   output logic [W-1:0] cg_d,
   output logic         cg_k
);
   if (W != CG_W) begin : g_bad_width
      $error("tx_cg_fsm supports 8-bit code groups only");
   end

   tx_state_e   state;
   logic        use_late;   // frame runs one stage behind
   logic        pending;    // enable seen during odd idle half
   logic        cur_en;
   logic [W-1:0] cur_d;
   logic        out_odd;

   assign cur_en  = use_late ? en_b : en_a;
   assign cur_d   = use_late ? d_b  : d_a;
   assign out_odd = ~next_odd;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         use_late <= 1'b0;
         pending  <= 1'b0;
         cg_d     <= CG_COMMA;
         cg_k     <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (!next_odd) begin
                  if (pending || en_a) begin
                     cg_d     <= CG_SOP;
                     cg_k     <= 1'b1;
                     use_late <= pending;
                     pending  <= 1'b0;
                     state    <= ST_FRAME;
                  end else begin
                     cg_d <= CG_COMMA;
                     cg_k <= 1'b1;
                  end
               end else begin
                  cg_d    <= CG_IDLE_D;
                  cg_k    <= 1'b0;
                  pending <= en_a;
               end
            end
            ST_FRAME: begin
               if (cur_en) begin
                  cg_d <= cur_d;
                  cg_k <= 1'b0;
               end else begin
                  cg_d  <= CG_EOP;
                  cg_k  <= 1'b1;
                  state <= ST_TERM;
               end
            end
            ST_TERM: begin
               cg_d  <= CG_CARRIER;
               cg_k  <= 1'b1;
               state <= next_odd ? ST_IDLE : ST_PAD;
            end
            ST_PAD: begin
               cg_d  <= CG_CARRIER;
               cg_k  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: a comma always sits on an even position and is followed by D16.2
   p_comma_even_r1: assert property (@(posedge clk) disable iff (rst)
      (cg_k && cg_d == CG_COMMA) |-> !out_odd);
   p_comma_pair_r1: assert property (@(posedge clk) disable iff (rst)
      (cg_k && cg_d == CG_COMMA) |=> (!cg_k && cg_d == CG_IDLE_D));
   // R3, R7: the start delimiter is always on an even position
   p_sop_even_r3: assert property (@(posedge clk) disable iff (rst)
      (cg_k && cg_d == CG_SOP) |-> !out_odd);
   // R5: end delimiter is followed by carrier extend
   p_eop_then_ext_r5: assert property (@(posedge clk) disable iff (rst)
      (cg_k && cg_d == CG_EOP) |=> (cg_k && cg_d == CG_CARRIER));
   // R6: after carrier extend comes another one or an even position
   p_realign_r6: assert property (@(posedge clk) disable iff (rst)
      (cg_k && cg_d == CG_CARRIER) |=> ((cg_k && cg_d == CG_CARRIER) || !out_odd));
endmodule

// File: rtl/pcs_tx_coder.sv
module pcs_tx_coder #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              gmii_en,
   input  logic [DATA_W-1:0] gmii_d,
   output logic [DATA_W-1:0] cg_data,
   output logic              cg_is_k
);
   localparam int unsigned ALIGN_STAGES = 2;

   if (DATA_W != 8) begin : g_bad_width
      $error("pcs_tx_coder: DATA_W must be 8");
   end

   logic                                next_odd;
   logic [ALIGN_STAGES-1:0]             tap_en;
   logic [ALIGN_STAGES-1:0][DATA_W-1:0] tap_d;

   tx_parity_toggle u_parity (
      .clk      (clk),
      .rst      (rst),
      .next_odd (next_odd)
   );

   tx_byte_pipe #(.W(DATA_W), .DEPTH(ALIGN_STAGES)) u_pipe (
      .clk    (clk),
      .rst    (rst),
      .in_en  (gmii_en),
      .in_d   (gmii_d),
      .tap_en (tap_en),
      .tap_d  (tap_d)
   );

   tx_cg_fsm #(.W(DATA_W)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .next_odd (next_odd),
      .en_a     (tap_en[0]),
      .d_a      (tap_d[0]),
      .en_b     (tap_en[1]),
      .d_b      (tap_d[1]),
      .cg_d     (cg_data),
      .cg_k     (cg_is_k)
   );
endmodule

// File: tb/tb_pcs_tx_coder.sv
`timescale 1ns/1ps
module tb_pcs_tx_coder;
   localparam int DEPTH = 2048;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       gmii_en = 1'b0;
   logic [7:0] gmii_d = 8'h00;
   logic [7:0] cg_data;
   logic       cg_is_k;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit checking = 1'b0;

   logic [7:0] exp_d [0:DEPTH-1];
   logic       exp_k [0:DEPTH-1];
   int         exp_r [0:DEPTH-1];

   always #2.5 clk = ~clk;

   pcs_tx_coder dut (
      .clk(clk), .rst(rst), .gmii_en(gmii_en), .gmii_d(gmii_d),
      .cg_data(cg_data), .cg_is_k(cg_is_k)
   );

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   task automatic check(input int req, input logic [7:0] d, input logic k);
      n_tests++;
      if (cg_data !== d || cg_is_k !== k) begin
         n_fail++;
         $display("FAIL R%0d cycle %0d: got %h/k%0b expected %h/k%0b",
                  req, cyc, cg_data, cg_is_k, d, k);
      end
   endtask

   // Every output position is compared with the precomputed stream
   always @(negedge clk) begin
      if (checking && !rst && cyc < DEPTH)
         check(exp_r[cyc], exp_d[cyc], exp_k[cyc]);
   end

   function automatic logic [7:0] byte_of(input int seed, input int i);
      return 8'((seed * 7 + i * 13 + 1) & 255);
   endfunction

   task automatic put(input int idx, input logic [7:0] d, input logic k, input int req);
      if (idx < DEPTH) begin
         exp_d[idx] = d; exp_k[idx] = k; exp_r[idx] = req;
      end
   endtask

   // Called at a negedge; the first byte is sampled at the next edge e.
   task automatic send_frame(input int n, input int seed);
      int e, s, req_sop;
      e = cyc + 1;
      s = (((e + 1) % 2) == 0) ? e + 1 : e + 2;
      // R3 start on even position; R7 delayed by one when it would be odd; R8 length one
      req_sop = (n == 1) ? 8 : ((s == e + 1) ? 3 : 7);
      put(s, 8'hFB, 1'b1, req_sop);
      for (int i = 1; i < n; i++)
         put(s + i, byte_of(seed, i), 1'b0, 4);      // R4 bytes pass through
      put(s + n,     8'hFD, 1'b1, (n == 1) ? 8 : 5); // R5 end delimiter
      put(s + n + 1, 8'hF7, 1'b1, 5);                // R5 carrier extend
      if (((s + n + 2) % 2) == 1)
         put(s + n + 2, 8'hF7, 1'b1, 6);             // R6 alignment pad
      for (int i = 0; i < n; i++) begin
         gmii_en = 1'b1;
         gmii_d  = byte_of(seed, i);
         @(negedge clk);
      end
      gmii_en = 1'b0;
      gmii_d  = 8'h00;
   endtask

   initial begin
      // R1 idle default: even comma, odd D16.2
      for (int j = 0; j < DEPTH; j++) begin
         exp_d[j] = (j % 2 == 0) ? 8'hBC : 8'h50;
         exp_k[j] = (j % 2 == 0);
         exp_r[j] = 1;
      end
      exp_r[1] = 2; // R2 first position after reset is odd idle

      repeat (3) @(negedge clk);
      check(2, 8'hBC, 1'b1); // R2 output during reset
      rst = 1'b0;
      checking = 1'b1;
      repeat (4) @(negedge clk);

      for (int n = 1; n <= 24; n++) begin
         for (int par = 0; par < 2; par++) begin
            repeat (6) @(negedge clk);
            if (((cyc + 2) % 2) != par) @(negedge clk);
            send_frame(n, n * 2 + par);
         end
      end
      repeat (10) @(negedge clk);
      checking = 1'b0;

      // R2 reset in the middle of a frame returns to idle at once
      gmii_en = 1'b1; gmii_d = 8'h3C;
      repeat (4) @(negedge clk);
      rst = 1'b1; gmii_en = 1'b0;
      @(negedge clk);
      check(2, 8'hBC, 1'b1);
      rst = 1'b0;
      @(negedge clk);
      check(2, 8'h50, 1'b0);
      @(negedge clk);
      check(1, 8'hBC, 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule